// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block holds the configuration of a programmable sum-of-products logic array: the fuse map that decides which input lines connect to which product terms, the architecture bits that pick the output cell modes, a 64-bit identification word, and a security flag. All of it is kept in registers, and the fuse map and architecture bits are always driven out to the logic array. A programmer reaches the store through one command port. It carries an operation code, a bit address and a data word. The block answers with a busy/done handshake.

A command is taken when `cmd_valid` is high and the block is not busy. The block then stays busy for a fixed number of cycles, applies the operation and pulses `done` for one cycle, with `err` and `rdata` valid in that cycle. Setting the security flag blocks verify reads, bit programming and both directions of identification-word access. Only a bulk erase clears the flag. The erase also opens every connection, clears the architecture bits and zeroes the identification word.

Top module: `cfgs_store`

## Requirements
- R1: After reset every fuse and architecture bit reads 0 (open), the identification word is 0, the store is unlocked, and `busy`, `done` and `err` are low.
- R2: A command is accepted at a rising edge where `cmd_valid` is high and `busy` is low. `busy` is high for exactly ERASE_CYCLES cycles for an erase, or ACCESS_CYCLES cycles for any other code, starting the cycle after acceptance. `done` is high for the single cycle after `busy` falls. `cmd_valid` while `busy` is high is ignored.
- R3: Operation codes on `cmd_op`: 1 bulk erase, 2 program bit, 3 read bit, 4 set lock, 5 write identification word, 6 read identification word. Codes 0 and 7 complete with `err` high and change nothing.
- R4: Program bit writes `cmd_wdata[0]` into the cell at `cmd_addr`. Addresses below FUSE_BITS are fuse cells (`fuse_map[addr]`). Addresses from FUSE_BITS up to FUSE_BITS+ARCH_BITS-1 are architecture cells (`arch_bits[addr-FUSE_BITS]`). The new value is visible on those outputs in the `done` cycle.
- R5: Read bit returns the addressed cell in `rdata[0]`, with all upper bits 0, in the `done` cycle.
- R6: Program or read at an address at or above FUSE_BITS+ARCH_BITS completes with `err` high, `rdata` 0, and no cell changed.
- R7: Bulk erase is never refused. It clears all fuse and architecture cells and the identification word, and it clears the lock.
- R8: Set lock raises `locked`. A program-bit command with `cmd_wdata[1]` high also raises `locked` in the same completion, after writing its bit. `locked` changes only in a `done` cycle.
- R9: While `locked` is high, program bit, read bit, identification write and identification read complete with `err` high and `rdata` 0, and leave all stored contents unchanged.
- R10: While unlocked, the identification write stores `cmd_wdata`, and the identification read returns the stored word on `rdata`.
- R11: `err` and `rdata` are 0 outside the `done` cycle. Accepted commands, including set lock while already locked, complete with `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W (12) | Cell address |
| cmd_wdata | input | SIG_BITS (64) | Bit value in [0], lock-after flag in [1], identification word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused, valid with done |
| rdata | output | SIG_BITS (64) | Read result, valid with done |
| locked | output | 1 | Security flag |
| fuse_map | output | FUSE_BITS (2048) | Fuse cells driven to the logic array |
| arch_bits | output | ARCH_BITS (18) | Architecture cells |

## Verification
Every result of a command is due in the `done` cycle. For a command accepted at edge k, that cycle follows edge k+N, where N is ERASE_CYCLES or ACCESS_CYCLES. The stored outputs, `locked`, `err` and `rdata` all change at that same edge. The bench drives on falling edges and counts the falling edges where `busy` is high, so it checks the busy length against N. It samples all results at the first falling edge with `busy` low, then checks one falling edge later that `done` has dropped and that no second command started.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_ERASE  = 3'd1,
      OP_PROG   = 3'd2,
      OP_READ   = 3'd3,
      OP_SEAL   = 3'd4,
      OP_SIG_WR = 3'd5,
      OP_SIG_RD = 3'd6,
      OP_RSVD   = 3'd7
   } cfgs_op_e;

   // positions inside the command data word
   localparam int VALUE_BIT = 0;
   localparam int SEAL_BIT  = 1;

endpackage

// File: rtl/cfgs_timer.sv
module cfgs_timer #(
   parameter int ERASE_CYCLES  = 8,
   parameter int ACCESS_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_op,
   output logic busy,
   output logic fire,
   output logic done
);
   localparam int MAXC = (ERASE_CYCLES > ACCESS_CYCLES) ? ERASE_CYCLES : ACCESS_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   if (ERASE_CYCLES < 1) begin : g_bad_erase
      $error("ERASE_CYCLES must be at least 1");
   end
   if (ACCESS_CYCLES < 1) begin : g_bad_access
      $error("ACCESS_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign fire = busy_q && (cnt_q == '0);
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= fire;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= long_op ? CW'(ERASE_CYCLES - 1) : CW'(ACCESS_CYCLES - 1);
         end else if (fire) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfgs_cells.sv
module cfgs_cells #(
   parameter int CELLS  = 2066,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_all,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_bit,
   output logic [CELLS-1:0]  cells_q,
   output logic              rd_bit
);
   if (CELLS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for CELLS");
   end

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n || clear_all) begin
            cells_q[i] <= 1'b0;
         end else if (wr_en && (addr == ADDR_W'(i))) begin
            cells_q[i] <= wr_bit;
         end
      end
   end

   always_comb begin
      rd_bit = 1'b0;
      if (addr < ADDR_W'(CELLS)) rd_bit = cells_q[addr];
   end
endmodule

// File: rtl/cfgs_guard.sv
module cfgs_guard
   import cfgs_pkg::*;
#(
   parameter int CELLS  = 2066,
   parameter int ADDR_W = 12
) (
   input  cfgs_op_e          op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              locked,
   output logic              refuse,
   output logic              do_erase,
   output logic              do_prog,
   output logic              do_read,
   output logic              do_seal,
   output logic              do_sig_wr,
   output logic              do_sig_rd
);
   logic in_range;
   logic needs_open;
   logic bad_code;

   assign in_range = addr < ADDR_W'(CELLS);

   always_comb begin
      needs_open = 1'b0;
      bad_code   = 1'b0;
      case (op)
         OP_PROG, OP_READ:     needs_open = 1'b1;
         OP_SIG_WR, OP_SIG_RD: needs_open = 1'b1;
         OP_NONE, OP_RSVD:     bad_code   = 1'b1;
         default:              ;
      endcase
   end

   assign refuse = bad_code
                || (needs_open && locked)
                || (((op == OP_PROG) || (op == OP_READ)) && !in_range);

   assign do_erase  = (op == OP_ERASE);
   assign do_seal   = (op == OP_SEAL);
   assign do_prog   = (op == OP_PROG)   && !refuse;
   assign do_read   = (op == OP_READ)   && !refuse;
   assign do_sig_wr = (op == OP_SIG_WR) && !refuse;
   assign do_sig_rd = (op == OP_SIG_RD) && !refuse;
endmodule

// File: rtl/cfgs_store.sv
module cfgs_store
   import cfgs_pkg::*;
#(
   parameter int TERMS         = 64,
   parameter int LINES         = 32,
   parameter int ARCH_BITS     = 18,
   parameter int SIG_BITS      = 64,
   parameter int ERASE_CYCLES  = 8,
   parameter int ACCESS_CYCLES = 3,
   localparam int FUSE_BITS    = TERMS * LINES,
   localparam int CELLS        = FUSE_BITS + ARCH_BITS,
   localparam int ADDR_W       = $clog2(CELLS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [SIG_BITS-1:0]  cmd_wdata,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic [SIG_BITS-1:0]  rdata,
   output logic                 locked,
   output logic [FUSE_BITS-1:0] fuse_map,
   output logic [ARCH_BITS-1:0] arch_bits
);
   if (SIG_BITS < 2) begin : g_bad_sig
      $error("SIG_BITS must hold the value and lock-after flags");
   end
   if (ARCH_BITS < 1) begin : g_bad_arch
      $error("ARCH_BITS must be at least 1");
   end

   logic                accept;
   cfgs_op_e            op_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [SIG_BITS-1:0] wdata_q;
   logic                fire;
   logic                refuse;
   logic                do_erase, do_prog, do_read, do_seal, do_sig_wr, do_sig_rd;
   logic [CELLS-1:0]    cells_q;
   logic                rd_bit;
   logic                lock_q;
   logic [SIG_BITS-1:0] sig_q;
   logic                err_q;
   logic [SIG_BITS-1:0] rdata_q;

   assign accept = cmd_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         op_q    <= cfgs_op_e'(cmd_op);
         addr_q  <= cmd_addr;
         wdata_q <= cmd_wdata;
      end
   end

   cfgs_timer #(
      .ERASE_CYCLES (ERASE_CYCLES),
      .ACCESS_CYCLES(ACCESS_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .long_op(cmd_op == 3'(OP_ERASE)),
      .busy   (busy),
      .fire   (fire),
      .done   (done)
   );

   cfgs_guard #(
      .CELLS (CELLS),
      .ADDR_W(ADDR_W)
   ) u_guard (
      .op       (op_q),
      .addr     (addr_q),
      .locked   (lock_q),
      .refuse   (refuse),
      .do_erase (do_erase),
      .do_prog  (do_prog),
      .do_read  (do_read),
      .do_seal  (do_seal),
      .do_sig_wr(do_sig_wr),
      .do_sig_rd(do_sig_rd)
   );

   cfgs_cells #(
      .CELLS (CELLS),
      .ADDR_W(ADDR_W)
   ) u_cells (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_all(fire && do_erase),
      .wr_en    (fire && do_prog),
      .addr     (addr_q),
      .wr_bit   (wdata_q[VALUE_BIT]),
      .cells_q  (cells_q),
      .rd_bit   (rd_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         sig_q   <= '0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         err_q   <= 1'b0;
         rdata_q <= '0;
         if (fire) begin
            err_q <= refuse;
            if (do_erase) begin
               lock_q <= 1'b0;
               sig_q  <= '0;
            end else if (do_seal || (do_prog && wdata_q[SEAL_BIT])) begin
               lock_q <= 1'b1;
            end
            if (do_sig_wr) sig_q <= wdata_q;
            if (do_read)   rdata_q <= {{(SIG_BITS-1){1'b0}}, rd_bit};
            if (do_sig_rd) rdata_q <= sig_q;
         end
      end
   end

   assign err       = err_q;
   assign rdata     = rdata_q;
   assign locked    = lock_q;
   assign fuse_map  = cells_q[FUSE_BITS-1:0];
   assign arch_bits = cells_q[CELLS-1:FUSE_BITS];
endmodule

// File: rtl/cfgs_store_checks.sv
module cfgs_store_checks #(
   parameter int SIG_BITS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_valid,
   input logic                busy,
   input logic                done,
   input logic                err,
   input logic [SIG_BITS-1:0] rdata,
   input logic                locked,
   input logic [SIG_BITS-1:0] sig_q
);
   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_busy_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   assert_busy_done_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_refused_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rdata == '0));

   assert_lock_moves_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked != $past(locked)) |-> done);

   assert_sig_frozen_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(sig_q));

   assert_quiet_outside_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!err && (rdata == '0)));
endmodule

bind cfgs_store cfgs_store_checks #(.SIG_BITS(SIG_BITS)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .rdata    (rdata),
   .locked   (locked),
   .sig_q    (sig_q)
);

// File: tb/cfgs_store_test.sv
module cfgs_store_test;
   localparam int FUSE  = 64 * 32;
   localparam int ARCH  = 18;
   localparam int CELLS = FUSE + ARCH;
   localparam int AW    = $clog2(CELLS + 1);
   localparam int EC    = 8;
   localparam int AC    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic [2:0]      cmd_op = '0;
   logic [AW-1:0]   cmd_addr = '0;
   logic [63:0]     cmd_wdata = '0;
   logic            busy, done, err, locked;
   logic [63:0]     rdata;
   logic [FUSE-1:0] fuse_map;
   logic [ARCH-1:0] arch_bits;

   int checks = 0;
   int errors = 0;

   logic [CELLS-1:0] m_cells;
   logic [63:0]      m_sig;
   logic             m_lock;

   always #2 clk = ~clk;

   cfgs_store uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
      .err(err), .rdata(rdata), .locked(locked), .fuse_map(fuse_map),
      .arch_bits(arch_bits)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_store(input string req);
      chk(fuse_map === m_cells[FUSE-1:0], {req, " fuse map"}, 64'(fuse_map), 64'(m_cells[FUSE-1:0]));
      chk(arch_bits === m_cells[CELLS-1:FUSE], {req, " arch bits"}, 64'(arch_bits), 64'(m_cells[CELLS-1:FUSE]));
      chk(locked === m_lock, {req, " lock flag"}, 64'(locked), 64'(m_lock));
   endtask

   // Issue one command, predict from the requirements, check in the done cycle.
   task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] addr,
                          input logic [63:0] wd, input bit poke);
      bit          exp_err;
      logic [63:0] exp_rd;
      int          exp_n;
      int          n;
      string       tag;
      bit          needs_open;
      exp_n = (op == 3'd1) ? EC : AC;
      needs_open = (op == 3'd2) || (op == 3'd3) || (op == 3'd5) || (op == 3'd6);
      exp_err = 1'b0;
      exp_rd  = '0;
      tag     = "R11";
      if (op == 3'd0 || op == 3'd7) begin
         exp_err = 1'b1; tag = "R3";
      end else if (needs_open && m_lock) begin
         exp_err = 1'b1; tag = "R9";
      end else if ((op == 3'd2 || op == 3'd3) && addr >= AW'(CELLS)) begin
         exp_err = 1'b1; tag = "R6";
      end
      if (!exp_err) begin
         case (op)
            3'd1: begin m_cells = '0; m_sig = '0; m_lock = 1'b0; tag = "R7"; end
            3'd2: begin m_cells[addr] = wd[0]; if (wd[1]) m_lock = 1'b1; tag = "R4"; end
            3'd3: begin exp_rd = {63'b0, m_cells[addr]}; tag = "R5"; end
            3'd4: begin m_lock = 1'b1; tag = "R8"; end
            3'd5: begin m_sig = wd; tag = "R10"; end
            3'd6: begin exp_rd = m_sig; tag = "R10"; end
            default: ;
         endcase
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke) begin
         cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = '0;
         cmd_wdata = {63'b0, ~m_cells[0]};
      end
      n = 0;
      while (busy === 1'b1 && n < 100) begin
         n++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(n == exp_n, "R2 busy length", 64'(n), 64'(exp_n));
      chk(done === 1'b1, "R2 done pulse", 64'(done), 64'd1);
      chk(err === exp_err, {tag, " err"}, 64'(err), 64'(exp_err));
      chk(rdata === exp_rd, {tag, " rdata"}, rdata, exp_rd);
      check_store(tag);
      @(negedge clk);
      chk(done === 1'b0, "R2 done single", 64'(done), 64'd0);
      chk(busy === 1'b0, "R2 no extra start", 64'(busy), 64'd0);
      chk(err === 1'b0 && rdata === '0, "R11 quiet", rdata, 64'd0);
      if (poke) chk(fuse_map[0] === m_cells[0], "R2 ignored while busy", 64'(fuse_map[0]), 64'(m_cells[0]));
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_cells = '0; m_sig = '0; m_lock = 1'b0;
      void'($urandom(32'h1f2e));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 handshake idle", {61'b0, busy, done, err}, 64'd0);
      check_store("R1");
      run_cmd(3'd6, '0, '0, 1'b0);                    // R1 word reads 0
      // R4 / R5 directed
      run_cmd(3'd2, AW'(5), 64'd1, 1'b0);
      run_cmd(3'd3, AW'(5), '0, 1'b0);
      run_cmd(3'd2, AW'(FUSE + 3), 64'd1, 1'b0);
      run_cmd(3'd2, AW'(CELLS - 1), 64'd1, 1'b0);
      run_cmd(3'd3, AW'(CELLS - 1), '0, 1'b0);
      run_cmd(3'd2, AW'(5), 64'd0, 1'b0);
      // R6 out of range, R3 bad codes
      run_cmd(3'd2, AW'(CELLS), 64'd1, 1'b0);
      run_cmd(3'd3, AW'(CELLS + 7), '0, 1'b0);
      run_cmd(3'd0, '0, 64'd1, 1'b0);
      run_cmd(3'd7, '0, 64'd1, 1'b0);
      // R10 identification word
      run_cmd(3'd5, '0, 64'hdead_beef_cafe_f00d, 1'b0);
      run_cmd(3'd6, '0, '0, 1'b0);
      // R2 request held while busy is ignored
      run_cmd(3'd3, AW'(FUSE + 3), '0, 1'b1);
      // R8 lock, R9 refusals, R11 relock accepted
      run_cmd(3'd4, '0, '0, 1'b0);
      run_cmd(3'd3, AW'(FUSE + 3), '0, 1'b0);
      run_cmd(3'd2, AW'(9), 64'd1, 1'b0);
      run_cmd(3'd6, '0, '0, 1'b0);
      run_cmd(3'd5, '0, 64'h1234, 1'b0);
      run_cmd(3'd4, '0, '0, 1'b0);
      // R7 erase unlocks and clears
      run_cmd(3'd1, '0, '0, 1'b0);
      run_cmd(3'd6, '0, '0, 1'b0);
      run_cmd(3'd3, AW'(FUSE + 3), '0, 1'b0);
      // R8 program with lock-after flag
      run_cmd(3'd2, AW'(40), 64'd3, 1'b0);
      run_cmd(3'd3, AW'(40), '0, 1'b0);
      run_cmd(3'd1, '0, '0, 1'b1);
      // random mix
      for (int i = 0; i < 500; i++) begin
         int unsigned r;
         logic [2:0]  op;
         r = $urandom_range(0, 99);
         if      (r < 3)  op = 3'd1;
         else if (r < 35) op = 3'd2;
         else if (r < 58) op = 3'd3;
         else if (r < 61) op = 3'd4;
         else if (r < 71) op = 3'd5;
         else if (r < 81) op = 3'd6;
         else if (r < 84) op = 3'($urandom_range(0, 1) * 7);
         else             op = 3'd2;
         run_cmd(op, AW'($urandom_range(0, CELLS + 20)),
                 {$urandom, $urandom_range(0, 3)}, ($urandom_range(0, 9) == 0));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule